// File: doc/BRIEF.md
# Parallel flash command sequence decoder

This block sits on the device side of an asynchronous parallel flash bus and interprets the stream of host write cycles. The bus front end has already captured each cycle's address on the leading (falling) edge of the write strobe and its data byte on the trailing (rising) edge. It hands the finished cycle to this block as a one-clock pulse `wr_stb`, with `wr_addr` and `wr_data` valid during that pulse. The decoder follows the two-write unlock prefix and the command byte that comes after it. It then launches word programming, whole-array erase or sector erase by pulsing a start output for the embedded algorithm, and it presents the target address, the target data and the set of sectors chosen for erase.

Sector erase has an open window after the first sector command. Further sector commands add sectors to the set and restart a countdown of `WINDOW_CYCLES` clocks, and the erase starts only when the countdown runs out. While a sector erase is running the host can suspend it and later resume it. Any malformed cycle, and the abort byte F0h, return the decoder to read-array mode.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and from then until the first accepted command, `mode` is 0 (read array), `sect_mask` is all zero and all four start pulses are low.
- R2: The writes AAh at 555h, 55h at 2AAh, A0h at 555h, then any byte other than F0h at any address, give a one-cycle `prog_go` in the cycle after the fourth write. In that same cycle `mode` becomes 1 (program) and `tgt_addr`/`tgt_data` hold the fourth write's address and data. The unlock addresses are compared on `wr_addr[10:0]` only, so the upper bits may be anything.
- R3: The writes AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 10h/555h give a one-cycle `chip_go` in the cycle after the sixth write, with `mode` = 2 (chip erase).
- R4: If the sixth write of the erase prefix is 30h at any address, `mode` becomes 3 (erase window) and `sect_mask` holds only bit k, where k = `wr_addr[AW-1 -: SECT_BITS]`.
- R5: In mode 3 each 30h write sets its sector's bit in `sect_mask` and restarts the countdown. `sect_go` is high exactly `WINDOW_CYCLES` cycles after the clock edge that took the last 30h, and in that cycle `mode` becomes 4 (sector erase).
- R6: Any write other than 30h during mode 3 returns `mode` to 0, clears `sect_mask` and prevents `sect_go`.
- R7: A cycle with a wrong address or data, or out of order, anywhere in an unlock prefix returns the decoder to read mode, so the rest of that sequence starts nothing.
- R8: F0h at any address, written partway through a prefix or in place of the program data, aborts to mode 0 with no start pulse.
- R9: Modes 1, 2 and 4 end, returning to mode 0 with `sect_mask` cleared, on the first clock edge with `alg_busy` low that does not fall in a start-pulse cycle. Writes in modes 1 and 2 are ignored.
- R10: B0h moves mode 4 to mode 5 (erase suspended). In every other mode B0h has no suspending effect.
- R11: In mode 5, `alg_busy` is ignored and only a 30h write is acted on. That write gives a one-cycle `resume_go` and returns `mode` to 4 with `sect_mask` kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse marking a completed bus write |
| wr_addr | input | AW | Address captured on the strobe's falling edge |
| wr_data | input | 8 | Data captured on the strobe's rising edge |
| alg_busy | input | 1 | Embedded program/erase algorithm is running |
| prog_go | output | 1 | Start word program |
| chip_go | output | 1 | Start whole-array erase |
| sect_go | output | 1 | Start erase of the sectors in `sect_mask` |
| resume_go | output | 1 | Resume the suspended sector erase |
| tgt_addr | output | AW | Program target address |
| tgt_data | output | 8 | Program target data |
| sect_mask | output | 2**SECT_BITS | Sectors selected for erase |
| mode | output | 3 | 0 read, 1 program, 2 chip erase, 3 erase window, 4 sector erase, 5 suspended |

## Verification
The unlock progress is hidden inside the decoder. A corrupted prefix state therefore shows at the ports only one cycle after the next command byte, as a start pulse that is missing or unexpected, so the bench checks every write's outcome in the cycle that follows it. A miscounted window shows as `sect_go` one or more cycles early or late, and is checked on both neighbouring cycles. A wrong exit from a busy mode shows in `mode` one cycle after `alg_busy` changes, or after a suspend or resume write.

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int AW            = 16,
  parameter int SECT_BITS     = 3,
  parameter int WINDOW_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    alg_busy,
  output logic                    prog_go,
  output logic                    chip_go,
  output logic                    sect_go,
  output logic                    resume_go,
  output logic [AW-1:0]           tgt_addr,
  output logic [7:0]              tgt_data,
  output logic [2**SECT_BITS-1:0] sect_mask,
  output logic [2:0]              mode
);
  localparam int NSECT = 2**SECT_BITS;
  localparam int CW    = $clog2(WINDOW_CYCLES + 1);

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PARM, S_E1, S_E2, S_E3,
    S_PGM, S_CHIP, S_WIN, S_SERA, S_SUSP
  } state_t;

  state_t          state;
  logic [CW-1:0]   win_cnt;

  wire at555   = wr_addr[10:0] == 11'h555;
  wire at2aa   = wr_addr[10:0] == 11'h2AA;
  wire go_any  = prog_go | chip_go | sect_go | resume_go;
  wire [NSECT-1:0] sect_bit = NSECT'(1) << wr_addr[AW-1 -: SECT_BITS];
  wire run_done = !alg_busy && !go_any;

  always_comb begin
    case (state)
      S_PGM:   mode = 3'd1;
      S_CHIP:  mode = 3'd2;
      S_WIN:   mode = 3'd3;
      S_SERA:  mode = 3'd4;
      S_SUSP:  mode = 3'd5;
      default: mode = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_READ;
      win_cnt   <= '0;
      prog_go   <= 1'b0;
      chip_go   <= 1'b0;
      sect_go   <= 1'b0;
      resume_go <= 1'b0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      sect_mask <= '0;
    end else begin
      prog_go   <= 1'b0;
      chip_go   <= 1'b0;
      sect_go   <= 1'b0;
      resume_go <= 1'b0;
      case (state)
        S_READ:
          if (wr_stb && wr_data == 8'hAA && at555) state <= S_U1;
        S_U1:
          if (wr_stb) state <= (wr_data == 8'h55 && at2aa) ? S_U2 : S_READ;
        S_U2:
          if (wr_stb) begin
            if (wr_data == 8'hA0 && at555)      state <= S_PARM;
            else if (wr_data == 8'h80 && at555) state <= S_E1;
            else                                state <= S_READ;
          end
        S_PARM:
          if (wr_stb) begin
            if (wr_data == 8'hF0) state <= S_READ;
            else begin
              state    <= S_PGM;
              prog_go  <= 1'b1;
              tgt_addr <= wr_addr;
              tgt_data <= wr_data;
            end
          end
        S_E1:
          if (wr_stb) state <= (wr_data == 8'hAA && at555) ? S_E2 : S_READ;
        S_E2:
          if (wr_stb) state <= (wr_data == 8'h55 && at2aa) ? S_E3 : S_READ;
        S_E3:
          if (wr_stb) begin
            if (wr_data == 8'h10 && at555) begin
              state   <= S_CHIP;
              chip_go <= 1'b1;
            end else if (wr_data == 8'h30) begin
              state     <= S_WIN;
              sect_mask <= sect_bit;
              win_cnt   <= CW'(WINDOW_CYCLES);
            end else state <= S_READ;
          end
        S_PGM, S_CHIP:
          if (run_done) state <= S_READ;
        S_WIN:
          if (wr_stb) begin
            if (wr_data == 8'h30) begin
              sect_mask <= sect_mask | sect_bit;
              win_cnt   <= CW'(WINDOW_CYCLES);
            end else begin
              state     <= S_READ;
              sect_mask <= '0;
            end
          end else if (win_cnt <= CW'(1)) begin
            state   <= S_SERA;
            sect_go <= 1'b1;
          end else win_cnt <= win_cnt - 1'b1;
        S_SERA:
          if (wr_stb && wr_data == 8'hB0) state <= S_SUSP;
          else if (run_done) begin
            state     <= S_READ;
            sect_mask <= '0;
          end
        S_SUSP:
          if (wr_stb && wr_data == 8'h30) begin
            state     <= S_SERA;
            resume_go <= 1'b1;
          end
        default: state <= S_READ;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int AW    = 16,
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             alg_busy,
  input logic             prog_go,
  input logic             chip_go,
  input logic             sect_go,
  input logic             resume_go,
  input logic [AW-1:0]    tgt_addr,
  input logic [NSECT-1:0] sect_mask,
  input logic [2:0]       mode
);
  AST_RESET_READ: assert property (@(posedge clk) !rst_n |=> (mode == 3'd0 && sect_mask == '0)); // R1
  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({prog_go, chip_go, sect_go, resume_go})); // R2
  AST_PROG_MODE: assert property (@(posedge clk) disable iff (!rst_n) prog_go |-> mode == 3'd1); // R2
  AST_PROG_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd1 && !prog_go) |-> $stable(tgt_addr)); // R2
  AST_CHIP_MODE: assert property (@(posedge clk) disable iff (!rst_n) chip_go |-> mode == 3'd2); // R3
  AST_WIN_MASK: assert property (@(posedge clk) disable iff (!rst_n) mode == 3'd3 |-> sect_mask != '0); // R4
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd3 && !wr_stb) |=> (mode == 3'd3 || (mode == 3'd4 && sect_go))); // R5
  AST_SECT_GO_MASK: assert property (@(posedge clk) disable iff (!rst_n) sect_go |-> (mode == 3'd4 && sect_mask != '0)); // R5
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (mode != 3'd4 && mode != 3'd5) |=> mode != 3'd5); // R10
  AST_SUSP_IGNORES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd5 && !wr_stb) |=> (mode == 3'd5 && $stable(sect_mask))); // R11
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.AW(AW), .NSECT(2**SECT_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .alg_busy(alg_busy),
  .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go), .resume_go(resume_go),
  .tgt_addr(tgt_addr), .sect_mask(sect_mask), .mode(mode)
);

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
  localparam int AW = 16, SB = 3, W = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0, alg_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_go, chip_go, sect_go, resume_go;
  logic [AW-1:0] tgt_addr;
  logic [7:0] tgt_data;
  logic [7:0] sect_mask;
  logic [2:0] mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_cmd_decoder #(.AW(AW), .SECT_BITS(SB), .WINDOW_CYCLES(W)) i_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .alg_busy(alg_busy), .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go),
    .resume_go(resume_go), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .sect_mask(sect_mask), .mode(mode));

  wire [3:0] pulses = {prog_go, chip_go, sect_go, resume_go};

  // {addr, data, expected mode, expected pulses {prog,chip,sect,resume}}
  localparam logic [30:0] VEC [38] = '{
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AA, 8'h55, 3'd0, 4'b0000},  // R2
    {16'h0555, 8'hA0, 3'd0, 4'b0000}, {16'hA123, 8'h5A, 3'd1, 4'b1000},
    {16'h0000, 8'hFF, 3'd1, 4'b0000}, {16'h0000, 8'hFF, 3'd0, 4'b0000},  // R9
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AB, 8'h55, 3'd0, 4'b0000},  // R7 bad addr
    {16'h0555, 8'hA0, 3'd0, 4'b0000}, {16'h0100, 8'h12, 3'd0, 4'b0000},
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AA, 8'h54, 3'd0, 4'b0000},  // R7 bad data
    {16'h02AA, 8'h55, 3'd0, 4'b0000}, {16'h0555, 8'hA0, 3'd0, 4'b0000},  // R7 order
    {16'h0000, 8'h33, 3'd0, 4'b0000},
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AA, 8'h55, 3'd0, 4'b0000},  // R8
    {16'h0555, 8'h80, 3'd0, 4'b0000}, {16'h0000, 8'hF0, 3'd0, 4'b0000},
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AA, 8'h55, 3'd0, 4'b0000},
    {16'h0555, 8'hA0, 3'd0, 4'b0000}, {16'h1234, 8'hF0, 3'd0, 4'b0000},
    {16'h0000, 8'h00, 3'd0, 4'b0000},
    {16'h0555, 8'hAA, 3'd0, 4'b0000}, {16'h02AA, 8'h55, 3'd0, 4'b0000},  // R3
    {16'h0555, 8'h80, 3'd0, 4'b0000}, {16'h0555, 8'hAA, 3'd0, 4'b0000},
    {16'h02AA, 8'h55, 3'd0, 4'b0000}, {16'h0555, 8'h10, 3'd2, 4'b0100},
    {16'h0000, 8'hAA, 3'd2, 4'b0000}, {16'h0000, 8'hAA, 3'd0, 4'b0000},
    {16'hF555, 8'hAA, 3'd0, 4'b0000}, {16'h72AA, 8'h55, 3'd0, 4'b0000},  // R2 upper bits
    {16'h1555, 8'hA0, 3'd0, 4'b0000}, {16'h0003, 8'h77, 3'd1, 4'b1000},
    {16'h0000, 8'hB0, 3'd1, 4'b0000}, {16'h0000, 8'h00, 3'd0, 4'b0000}   // R10 B0 in program
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic erase_prefix();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    check("R1 reset mode", 32'(mode), 0);
    check("R1 reset mask", 32'(sect_mask), 0);
    check("R1 reset pulses", 32'(pulses), 0);
    rst_n = 1'b1;
    idle(1);

    foreach (VEC[i]) begin
      wr(VEC[i][30:15], VEC[i][14:7]);
      check($sformatf("R2/R3/R7/R8/R9 vec%0d mode", i), 32'(mode), 32'(VEC[i][6:4]));
      check($sformatf("R2/R3/R7/R8/R9 vec%0d pulses", i), 32'(pulses), 32'(VEC[i][3:0]));
    end
    check("R2 tgt_addr", 32'(tgt_addr), 32'h0003);
    check("R2 tgt_data", 32'(tgt_data), 32'h77);

    // R9 program held by busy, writes ignored
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h4000, 8'hC3);
    check("R2 prog_go", 32'(prog_go), 1);
    alg_busy = 1'b1;
    wr(16'h0555, 8'hAA); idle(3);
    check("R9 program held while busy", 32'(mode), 1);
    check("R9 write ignored keeps target", 32'(tgt_data), 32'hC3);
    alg_busy = 1'b0; idle(1);
    check("R9 program ends on busy low", 32'(mode), 0);

    // R4/R5 sector window
    erase_prefix();
    wr(16'h2000, 8'h30);
    check("R4 window mode", 32'(mode), 3);
    check("R4 first sector mask", 32'(sect_mask), 32'h02);
    idle(3);
    wr(16'hE000, 8'h30);
    check("R5 mask accumulates", 32'(sect_mask), 32'h82);
    idle(W - 1);
    check("R5 no early sect_go", 32'(sect_go), 0);
    check("R5 still window", 32'(mode), 3);
    idle(1);
    check("R5 sect_go on time", 32'(sect_go), 1);
    check("R5 sector erase mode", 32'(mode), 4);
    alg_busy = 1'b1;
    idle(2);
    check("R9 sector erase held", 32'(mode), 4);

    // R10/R11 suspend and resume
    wr(16'h0000, 8'hB0);
    check("R10 suspend", 32'(mode), 5);
    alg_busy = 1'b0; idle(2);
    check("R11 busy ignored in suspend", 32'(mode), 5);
    wr(16'h0555, 8'hAA);
    check("R11 other write ignored", 32'(mode), 5);
    wr(16'h0000, 8'h30);
    check("R11 resume pulse", 32'(resume_go), 1);
    check("R11 resume mode", 32'(mode), 4);
    check("R11 mask kept", 32'(sect_mask), 32'h82);
    alg_busy = 1'b1; idle(1);
    alg_busy = 1'b0; idle(1);
    check("R9 erase done mode", 32'(mode), 0);
    check("R9 erase done mask", 32'(sect_mask), 0);
    wr(16'h0000, 8'hB0);
    check("R10 B0 in read ignored", 32'(mode), 0);

    // R6 window abort
    erase_prefix();
    wr(16'h6000, 8'h30);
    wr(16'h02AA, 8'h55);
    check("R6 abort mode", 32'(mode), 0);
    check("R6 abort mask", 32'(sect_mask), 0);
    begin
      int seen = 0;
      for (int i = 0; i < W + 2; i++) begin
        @(negedge clk);
        if (sect_go) seen++;
      end
      check("R6 no sect_go after abort", 32'(seen), 0);
    end

    // R1 reset mid-window
    erase_prefix();
    wr(16'h8000, 8'h30);
    rst_n = 1'b0; idle(1);
    check("R1 reset clears window", 32'(mode), 0);
    check("R1 reset clears mask", 32'(sect_mask), 0);
    rst_n = 1'b1; idle(W + 2);
    check("R1 no pulse after reset", 32'(pulses), 0);

    finish_run();
  end
endmodule